// File: doc/BRIEF.md
# Deflection-routing shuffle-exchange node

This block is a single 2x2 switching node for a shuffle-exchange fabric that is extended past log2(N) stages and resolves output conflicts by deflection rather than buffering. Each arriving cell brings its destination address, a routing tag held least-used-bit-first, a count of routing bits still to consume, the label of the node it sits in, the number of stages it has already crossed, and an age value. The node steers each cell to the output named by the tag's current bit. It drops that bit, shuffles the node label by shifting the chosen output bit in at the bottom, and bumps the stage count. All outputs are registered, so one node forms one pipeline stage of the fabric.

When both cells ask for the same output, the older cell (larger age) wins and the upper input wins a tie. The loser leaves on the other output with its tag rebuilt from the full destination, so its routing starts over from whichever node it lands in. A cell that consumes its last routing bit on the correct output is delivered: the node raises a per-output delivery strobe with the physical output address for the external collecting multiplexer, and the link carries an idle slot onward. A cell that would enter stage L without having been delivered is reported lost on the output it would have taken and is also removed.

Top module: `sen_node`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, every out_vld, dlv_vld and lost_vld bit is 0, whatever the inputs carry.
- R2: A lone valid cell leaves, one clock after it is presented, on the output port equal to bit 0 of its in_tag (0 = upper, 1 = lower).
- R3: A correctly routed cell that is neither delivered nor lost appears with tag shifted right by one, remaining count reduced by one (never 0 on a valid output), stage count plus one, and label ((label << 1) | port) truncated to log2(N)-1 bits.
- R4: Two valid cells never leave on the same output port. Cells that want different ports both get them.
- R5: When both valid cells want the same port, the cell with the larger in_age wins it. With equal ages the cell on input 0 wins.
- R6: The losing cell takes the other port, and its tag is reset to the destination with bit order reversed (tag bit 0 = destination MSB), with the remaining count set to log2(N). Its label is shuffled with the port actually taken.
- R7: A cell that is not delivered and whose incremented stage count reaches MAX_STAGES raises lost_vld on the port it took, with out_vld low there.
- R8: A cell routed correctly with a remaining count of 1 raises dlv_vld on its port with dlv_addr = {label, port}, and out_vld is low there. Delivery takes precedence over loss at the last stage.
- R9: An output port that no valid cell selects shows out_vld, dlv_vld and lost_vld all 0 and all data fields 0.
- R10: Destination and age of a forwarded cell pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 2 | Cell present on input 0 / 1 |
| in_dst | input | 2 x AW | Destination address, MSB first |
| in_tag | input | 2 x AW | Routing tag, current bit at bit 0 |
| in_rem | input | 2 x RW | Routing bits still to consume (1..AW) |
| in_lab | input | 2 x LW | Label of this node as carried by the cell |
| in_stg | input | 2 x SW | Stages already crossed (< MAX_STAGES) |
| in_age | input | 2 x AGE_W | Age, larger wins contention |
| out_vld | output | 2 | Cell forwarded on output 0 / 1 |
| out_dst | output | 2 x AW | Forwarded destination |
| out_tag | output | 2 x AW | Forwarded routing tag |
| out_rem | output | 2 x RW | Forwarded remaining count |
| out_lab | output | 2 x LW | Label of the next-stage node |
| out_stg | output | 2 x SW | Forwarded stage count |
| out_age | output | 2 x AGE_W | Forwarded age |
| dlv_vld | output | 2 | Cell delivered on output 0 / 1 |
| dlv_addr | output | 2 x AW | Physical output address of the delivered cell |
| lost_vld | output | 2 | Cell lost on output 0 / 1 |

## Verification
The bench builds the node with N_PORTS = 8 and MAX_STAGES = 5, so labels are 2 bits, tags 3 bits and the stage limit lies close enough for random stage counts to hit the lost path often. A 3-bit age gives frequent ties as well as clear age wins, so both arms of the contention rule appear. Random cells are generated with a tag and label consistent with a partly completed route, so delivery at a remaining count of 1, deflection, loss and plain forwarding all occur in the same run.

// File: rtl/sen_pkg.sv
package sen_pkg;

  localparam int unsigned FW = 16;

  typedef enum logic [1:0] {
    FATE_NONE = 2'd0,
    FATE_FWD  = 2'd1,
    FATE_DLV  = 2'd2,
    FATE_LOST = 2'd3
  } fate_e;

  // reverse the low w bits of v
  function automatic logic [FW-1:0] flip_bits(input logic [FW-1:0] v, input int w);
    logic [FW-1:0] r;
    r = '0;
    for (int b = 0; b < FW; b++) begin
      if (b < w) r[w-1-b] = v[b];
    end
    return r;
  endfunction

  // next node label: shift the taken port in at the bottom, keep w bits
  function automatic logic [FW-1:0] shuffle_next(input logic [FW-1:0] lab, input logic port, input int w);
    logic [FW-1:0] msk;
    msk = (FW'(1) << w) - FW'(1);
    return ((lab << 1) | FW'(port)) & msk;
  endfunction

endpackage

// File: rtl/sen_arbiter.sv
module sen_arbiter #(
  parameter int AGE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       vld,
  input  logic [1:0]       want,
  input  logic [AGE_W-1:0] age_up,
  input  logic [AGE_W-1:0] age_dn,
  output logic [1:0]       gport,
  output logic [1:0]       defl,
  output logic             evt_clash,
  output logic             evt_up_wins
);

  always_comb begin
    evt_clash   = vld[0] & vld[1] & (want[0] == want[1]);
    evt_up_wins = (age_up >= age_dn);
    gport[0]    = (evt_clash && !evt_up_wins) ? ~want[0] : want[0];
    gport[1]    = (evt_clash &&  evt_up_wins) ? ~want[1] : want[1];
    defl[0]     = vld[0] & (gport[0] != want[0]);
    defl[1]     = vld[1] & (gport[1] != want[1]);
  end

  // R4: two live cells never share an output port
  assert_port_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == 2'b11) |-> (gport[0] != gport[1]));

  // R5: a clash deflects exactly one cell, never without a clash
  assert_one_loser_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clash |-> ($countones(defl) == 1));

  assert_no_spurious_defl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_clash |-> (defl == 2'b00));

endmodule

// File: rtl/sen_hop.sv
module sen_hop #(
  parameter int AW         = 3,
  parameter int MAX_STAGES = 8,
  parameter int AGE_W      = 3,
  localparam int LW = AW - 1,
  localparam int RW = $clog2(AW + 1),
  localparam int SW = $clog2(MAX_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              port,
  input  logic              defl,
  input  logic [AW-1:0]     dst,
  input  logic [AW-1:0]     tag,
  input  logic [RW-1:0]     rem,
  input  logic [LW-1:0]     lab,
  input  logic [SW-1:0]     stg,
  output sen_pkg::fate_e    fate,
  output logic [AW-1:0]     n_tag,
  output logic [RW-1:0]     n_rem,
  output logic [LW-1:0]     n_lab,
  output logic [SW-1:0]     n_stg,
  output logic [AW-1:0]     d_addr
);
  import sen_pkg::*;

  logic [SW:0] stg_inc;
  logic        evt_reached;
  logic        evt_expired;

  always_comb begin
    stg_inc     = {1'b0, stg} + (SW+1)'(1);
    evt_reached = vld & ~defl & (rem == RW'(1));
    evt_expired = (stg_inc >= (SW+1)'(MAX_STAGES));

    if (!vld)             fate = FATE_NONE;
    else if (evt_reached) fate = FATE_DLV;
    else if (evt_expired) fate = FATE_LOST;
    else                  fate = FATE_FWD;

    if (defl) begin
      n_tag = AW'(flip_bits(FW'(dst), AW));
      n_rem = RW'(AW);
    end else begin
      n_tag = tag >> 1;
      n_rem = rem - RW'(1);
    end
    n_lab  = LW'(shuffle_next(FW'(lab), port, LW));
    n_stg  = stg_inc[SW-1:0];
    d_addr = {lab, port};
  end

  // R3: a forwarded cell always keeps at least one routing bit
  assert_fwd_has_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fate == FATE_FWD) |-> (n_rem != '0));

  // R6: a deflected cell is never delivered here
  assert_defl_not_dlv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    defl |-> (fate != FATE_DLV));

endmodule

// File: rtl/sen_node.sv
module sen_node #(
  parameter int N_PORTS    = 8,
  parameter int MAX_STAGES = 8,
  parameter int AGE_W      = 3,
  localparam int AW = $clog2(N_PORTS),
  localparam int LW = AW - 1,
  localparam int RW = $clog2(AW + 1),
  localparam int SW = $clog2(MAX_STAGES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             in_vld,
  input  logic [1:0][AW-1:0]     in_dst,
  input  logic [1:0][AW-1:0]     in_tag,
  input  logic [1:0][RW-1:0]     in_rem,
  input  logic [1:0][LW-1:0]     in_lab,
  input  logic [1:0][SW-1:0]     in_stg,
  input  logic [1:0][AGE_W-1:0]  in_age,
  output logic [1:0]             out_vld,
  output logic [1:0][AW-1:0]     out_dst,
  output logic [1:0][AW-1:0]     out_tag,
  output logic [1:0][RW-1:0]     out_rem,
  output logic [1:0][LW-1:0]     out_lab,
  output logic [1:0][SW-1:0]     out_stg,
  output logic [1:0][AGE_W-1:0]  out_age,
  output logic [1:0]             dlv_vld,
  output logic [1:0][AW-1:0]     dlv_addr,
  output logic [1:0]             lost_vld
);
  import sen_pkg::*;

  logic [1:0]          want;
  logic [1:0]          gport;
  logic [1:0]          defl;
  logic                evt_clash;
  logic                evt_up_wins;
  fate_e               h_fate [2];
  logic [1:0][AW-1:0]  h_tag;
  logic [1:0][RW-1:0]  h_rem;
  logic [1:0][LW-1:0]  h_lab;
  logic [1:0][SW-1:0]  h_stg;
  logic [1:0][AW-1:0]  h_addr;

  always_comb begin
    for (int i = 0; i < 2; i++) want[i] = in_tag[i][0];
  end

  sen_arbiter #(.AGE_W(AGE_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld         (in_vld),
    .want        (want),
    .age_up      (in_age[0]),
    .age_dn      (in_age[1]),
    .gport       (gport),
    .defl        (defl),
    .evt_clash   (evt_clash),
    .evt_up_wins (evt_up_wins)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_hop
    sen_hop #(.AW(AW), .MAX_STAGES(MAX_STAGES), .AGE_W(AGE_W)) u_hop (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (in_vld[gi]),
      .port   (gport[gi]),
      .defl   (defl[gi]),
      .dst    (in_dst[gi]),
      .tag    (in_tag[gi]),
      .rem    (in_rem[gi]),
      .lab    (in_lab[gi]),
      .stg    (in_stg[gi]),
      .fate   (h_fate[gi]),
      .n_tag  (h_tag[gi]),
      .n_rem  (h_rem[gi]),
      .n_lab  (h_lab[gi]),
      .n_stg  (h_stg[gi]),
      .d_addr (h_addr[gi])
    );
  end

  // per output port: which input, if any, lands here
  for (genvar gp = 0; gp < 2; gp++) begin : g_port
    logic  hit_up, hit_dn, sel;
    fate_e f;

    always_comb begin
      hit_up = in_vld[0] && (gport[0] == 1'(gp));
      hit_dn = in_vld[1] && (gport[1] == 1'(gp));
      sel    = hit_dn;
      f      = (hit_up || hit_dn) ? h_fate[sel] : FATE_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_vld[gp]  <= 1'b0;
        out_dst[gp]  <= '0;
        out_tag[gp]  <= '0;
        out_rem[gp]  <= '0;
        out_lab[gp]  <= '0;
        out_stg[gp]  <= '0;
        out_age[gp]  <= '0;
        dlv_vld[gp]  <= 1'b0;
        dlv_addr[gp] <= '0;
        lost_vld[gp] <= 1'b0;
      end else begin
        out_vld[gp]  <= (f == FATE_FWD);
        out_dst[gp]  <= (f == FATE_FWD) ? in_dst[sel] : '0;
        out_tag[gp]  <= (f == FATE_FWD) ? h_tag[sel]  : '0;
        out_rem[gp]  <= (f == FATE_FWD) ? h_rem[sel]  : '0;
        out_lab[gp]  <= (f == FATE_FWD) ? h_lab[sel]  : '0;
        out_stg[gp]  <= (f == FATE_FWD) ? h_stg[sel]  : '0;
        out_age[gp]  <= (f == FATE_FWD) ? in_age[sel] : '0;
        dlv_vld[gp]  <= (f == FATE_DLV);
        dlv_addr[gp] <= (f == FATE_DLV) ? h_addr[sel] : '0;
        lost_vld[gp] <= (f == FATE_LOST);
      end
    end

    // R7: nothing forwarded ever sits at or beyond the stage limit
    assert_stage_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[gp] |-> (out_stg[gp] < SW'(MAX_STAGES)));

    // R8: a delivered or lost cell leaves an idle slot behind
    assert_dlv_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_vld[gp] |-> (!out_vld[gp] && !lost_vld[gp]));

    assert_lost_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lost_vld[gp] |-> !out_vld[gp]);

    // R3: a live outgoing cell still has a routing bit to use
    assert_out_rem_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[gp] |-> (out_rem[gp] != '0));
  end

  // R9: no input cells means nothing on any output next cycle
  assert_idle_in_idle_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == 2'b00) |=> ((out_vld == 2'b00) && (dlv_vld == 2'b00) && (lost_vld == 2'b00)));

endmodule

// File: tb/sen_node_bench.sv
module sen_node_bench;
  localparam int NP = 8, LS = 5, AGW = 3;
  localparam int AWB = 3, LWB = 2, RWB = 2, SWB = 3;
  localparam int EW = 1 + AWB + AWB + RWB + LWB + SWB + AGW + 1 + AWB + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]             in_vld;
  logic [1:0][AWB-1:0]    in_dst, in_tag;
  logic [1:0][RWB-1:0]    in_rem;
  logic [1:0][LWB-1:0]    in_lab;
  logic [1:0][SWB-1:0]    in_stg;
  logic [1:0][AGW-1:0]    in_age;
  logic [1:0]             out_vld, dlv_vld, lost_vld;
  logic [1:0][AWB-1:0]    out_dst, out_tag, dlv_addr;
  logic [1:0][RWB-1:0]    out_rem;
  logic [1:0][LWB-1:0]    out_lab;
  logic [1:0][SWB-1:0]    out_stg;
  logic [1:0][AGW-1:0]    out_age;

  sen_node #(.N_PORTS(NP), .MAX_STAGES(LS), .AGE_W(AGW)) u_sen_node (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_dst(in_dst), .in_tag(in_tag), .in_rem(in_rem),
    .in_lab(in_lab), .in_stg(in_stg), .in_age(in_age),
    .out_vld(out_vld), .out_dst(out_dst), .out_tag(out_tag), .out_rem(out_rem),
    .out_lab(out_lab), .out_stg(out_stg), .out_age(out_age),
    .dlv_vld(dlv_vld), .dlv_addr(dlv_addr), .lost_vld(lost_vld)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  function automatic logic [AWB-1:0] rev3(input logic [AWB-1:0] d);
    return {d[0], d[1], d[2]};
  endfunction

  // bench-side restatement of R2..R10 for one output port
  task automatic predict(input int p, output logic [EW-1:0] e, output string why);
    int loser;
    logic [1:0] go;
    logic v, dl, lo, ok;
    logic [AWB-1:0] d, t, da;
    logic [RWB-1:0] r;
    logic [LWB-1:0] l;
    logic [SWB-1:0] s;
    logic [AGW-1:0] a;
    int nxt;
    loser = -1;
    if (in_vld == 2'b11 && in_tag[0][0] == in_tag[1][0])
      loser = (in_age[1] > in_age[0]) ? 0 : 1;
    for (int i = 0; i < 2; i++) go[i] = (i == loser) ? ~in_tag[i][0] : in_tag[i][0];
    v = 0; dl = 0; lo = 0; d = 0; t = 0; da = 0; r = 0; l = 0; s = 0; a = 0;
    why = "R9";
    for (int i = 0; i < 2; i++) begin
      if (in_vld[i] && go[i] == p[0]) begin
        ok  = (i != loser);
        nxt = int'(in_stg[i]) + 1;
        if (ok && in_rem[i] == 1) begin
          dl = 1; da = {in_lab[i], p[0]}; why = "R8";
        end else if (nxt >= LS) begin
          lo = 1; why = "R7";
        end else begin
          v = 1; d = in_dst[i]; a = in_age[i]; s = SWB'(nxt);
          l = {in_lab[i][0], p[0]};
          if (ok) begin t = in_tag[i] >> 1; r = in_rem[i] - 1; why = "R3"; end
          else    begin t = rev3(in_dst[i]); r = 2'd3; why = "R6"; end
        end
      end
    end
    e = {v, d, t, r, l, s, a, dl, da, lo};
  endtask

  task automatic check_ports(input string note);
    logic [EW-1:0] e, act;
    string why;
    for (int p = 0; p < 2; p++) begin
      predict(p, e, why);
      act = {out_vld[p], out_dst[p], out_tag[p], out_rem[p], out_lab[p], out_stg[p],
             out_age[p], dlv_vld[p], dlv_addr[p], lost_vld[p]};
      n_chk++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s %s port %0d actual %h expected %h", why, note, p, act, e);
      end
    end
  endtask

  // cell with a consistent partly-used route: rem bits still to go
  task automatic set_cell(input int i, input logic v, input logic [AWB-1:0] dst,
                          input int rem, input logic [LWB-1:0] lab_rnd,
                          input int stg, input int age);
    int used;
    logic [LWB-1:0] msk;
    used = AWB - rem;
    msk = LWB'((1 << used) - 1);
    in_vld[i] = v;
    in_dst[i] = dst;
    in_tag[i] = rev3(dst) >> used;
    in_rem[i] = RWB'(rem);
    in_lab[i] = (lab_rnd & ~msk) | (LWB'(dst >> (AWB - used)) & msk);
    in_stg[i] = SWB'(stg);
    in_age[i] = AGW'(age);
  endtask

  task automatic step(input string note);
    @(posedge clk);
    @(negedge clk);
    check_ports(note);
  endtask

  initial begin
    in_vld = '0; in_dst = '0; in_tag = '0; in_rem = '0;
    in_lab = '0; in_stg = '0; in_age = '0;
    void'($urandom(32'd20240611));

    // R1: valid cells during reset must not appear
    set_cell(0, 1, 3'd5, 3, 2'd1, 0, 0);
    set_cell(1, 1, 3'd2, 3, 2'd3, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({out_vld, dlv_vld, lost_vld} !== 6'b0) begin
      n_bad++;
      $display("FAIL R1 during reset actual %b expected 000000", {out_vld, dlv_vld, lost_vld});
    end
    in_vld = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({out_vld, dlv_vld, lost_vld} !== 6'b0) begin
      n_bad++;
      $display("FAIL R1 after release actual %b expected 000000", {out_vld, dlv_vld, lost_vld});
    end

    // R2: lone cell, dst 5 = 101, first bit 1 -> lower port
    set_cell(0, 1, 3'd5, 3, 2'd2, 0, 4); in_vld[1] = 0;
    step("R2 lone upper cell to port 1, R10 age kept");
    // R2: lone cell on lower input, dst 2 = 010 -> upper port
    in_vld[0] = 0; set_cell(1, 1, 3'd2, 3, 2'd1, 1, 6);
    step("R2 lone lower cell to port 0");
    // R4: different wishes
    set_cell(0, 1, 3'd1, 3, 2'd0, 0, 0); set_cell(1, 1, 3'd6, 3, 2'd0, 0, 0);
    step("R4 no clash both served");
    // R5: clash, equal ages -> upper wins, R6 lower deflected
    set_cell(0, 1, 3'd4, 3, 2'd0, 0, 2); set_cell(1, 1, 3'd7, 3, 2'd0, 0, 2);
    step("R5 tie upper wins, R6 restart");
    // R5: clash, lower older
    set_cell(0, 1, 3'd4, 3, 2'd0, 0, 1); set_cell(1, 1, 3'd6, 3, 2'd0, 0, 5);
    step("R5 older lower wins, R4");
    // R8: delivery with rem 1
    set_cell(0, 1, 3'd6, 1, 2'd0, 2, 0); in_vld[1] = 0;
    step("R8 delivery dlv_addr");
    // R7: stage limit without delivery
    set_cell(0, 1, 3'd3, 2, 2'd0, LS - 1, 0); in_vld[1] = 0;
    step("R7 lost at limit");
    // R8: delivery beats loss at last stage
    set_cell(0, 1, 3'd3, 1, 2'd0, LS - 1, 0); in_vld[1] = 0;
    step("R8 delivery over loss");
    // R6: deflected last-bit cell is not delivered
    set_cell(0, 1, 3'd5, 1, 2'd0, 1, 7); set_cell(1, 1, 3'd7, 1, 2'd0, 1, 3);
    step("R6 deflected at last bit, R8 winner delivered");
    // R9: nothing in
    in_vld = 2'b00;
    step("R9 idle inputs");

    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < 2; i++)
        set_cell(i, ($urandom % 4) != 0, AWB'($urandom), 1 + ($urandom % 3),
                 LWB'($urandom), $urandom % LS, $urandom % 8);
      step("random R10");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule